// File: doc/BRIEF.md
# Programmable Vectored Interrupt Controller

This block arbitrates eight interrupt request inputs under a fixed priority scheme and hands a processor an 8-bit vector when the processor acknowledges. Software programs it through a byte-wide register interface. An even and an odd address carry initialization words, operation commands and the mask. A third address holds a per-input trigger-mode register. Until the initialization sequence finishes, the controller raises no interrupt.

The initialization sequence starts with a write to the even address that has bit 4 set. The odd-address writes that follow are taken, in order, as the vector base, the cascade configuration, and (when bit 0 of the first word was set) the mode word. After that, odd-address writes load the mask. Even-address writes are commands. They select which register the even address reads back, or they clear one in-service bit. When the processor strobes acknowledge, the highest-priority eligible request moves into service. The vector appears on a one-cycle output. If no request is eligible at that moment, the controller reports input 7 as a spurious interrupt.

Top module: `prio_intc`

## Requirements
- R1: After reset the mask reads 0xFF at address 1, the even address reads the request register, the trigger register reads 0x00, and int_out and vec_valid are low.
- R2: An even-address write with bit 4 set starts initialization. It clears the in-service register and sets the mask to 0xFF. The next odd writes load the vector base (bits 7:3 kept), then cascade_cfg, then the mode word if bit 0 of the first word was 1. Until the sequence ends, int_out stays low.
- R3: Once initialized, an odd-address write loads the mask, and an odd-address read returns it. A mask bit of 1 blocks that input from int_out.
- R4: An even-address write of 0x0A makes later even reads return the request register. A write of 0x0B makes them return the in-service register.
- R5: Input 0 has the highest priority. int_out is high only when an unmasked pending request has a higher priority than every in-service bit.
- R6: An acknowledge strobe in cycle N puts the vector {base[7:3], index} on vec_out, with vec_valid high in cycle N+1 only. The winning input's in-service bit is set, and an edge-latched request for that input is consumed.
- R7: An even-address write of 0x60+n clears in-service bit n and no other bit.
- R8: With mode word bit 1 set (auto end-of-interrupt), an acknowledge leaves the in-service register unchanged.
- R9: At address 2, trigger bit n = 1 makes input n level-sensed: the request follows the pin. A 0 makes it edge-sensed: the request latches on a rising edge and clears when the pin is low or when the request is acknowledged.
- R10: An acknowledge with no eligible request returns vector {base[7:3], 7} and changes no in-service bit. This happens even when input 7 is masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | 0 even/command, 1 odd/mask, 2 trigger register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr (combinational) |
| irq_in | input | 8 | Interrupt request inputs |
| int_out | output | 1 | Interrupt request to the processor |
| inta | input | 1 | One-cycle acknowledge strobe |
| vec_valid | output | 1 | Vector valid, one cycle after acknowledge |
| vec_out | output | 8 | Vector of the acknowledged input |
| cascade_cfg | output | 8 | Third initialization word, held |

## Verification
A corrupted in-service register is visible within one cycle on int_out, because it either blocks lower-priority requests or fails to block them. It also shows on the next even-address read after 0x0B. A wrong winner or a wrong base appears on vec_out in the cycle after the acknowledge strobe. A lost or stale edge latch shows up in the request read-back on the clock after the pin moves. The bench compares every acknowledge against a priority function run over random masks and requests. It then clears the in-service bit and checks it, so any state left behind breaks the next iteration's int_out check.

// File: rtl/prio_intc.sv
module prio_intc (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [7:0] irq_in,
  output logic       int_out,
  input  logic       inta,
  output logic       vec_valid,
  output logic [7:0] vec_out,
  output logic [7:0] cascade_cfg
);

  typedef enum logic [2:0] {ST_OFF, ST_BASE, ST_CASC, ST_MODE, ST_RUN} init_st_t;

  init_st_t   st;
  logic [7:0] mask_q, isr_q, edge_q, prev_q, trig_q;
  logic [4:0] base_q;
  logic       aeoi_q, need_mode_q, sel_isr_q;

  logic [7:0] irr, pend, allowed, elig, isr_n, edge_n;
  logic [2:0] win;
  logic       has_win, ready, even_wr, odd_wr, init_cmd, ack, eoi_cmd;

  assign ready    = (st == ST_RUN);
  assign even_wr  = wr_en && addr == 2'd0;
  assign odd_wr   = wr_en && addr == 2'd1;
  assign init_cmd = even_wr && wdata[4];
  assign eoi_cmd  = even_wr && !wdata[4] && wdata[7:3] == 5'b01100;
  assign ack      = inta && ready;

  assign irr  = (trig_q & irq_in) | (~trig_q & edge_q);
  assign pend = irr & ~mask_q;

  always_comb begin
    allowed[0] = 1'b1;
    for (int i = 1; i < 8; i++) allowed[i] = allowed[i-1] & ~isr_q[i-1];
    allowed = allowed & ~isr_q;
  end

  assign elig = pend & allowed;

  always_comb begin
    has_win = 1'b0;
    win     = 3'd7;
    for (int i = 7; i >= 0; i--) begin
      if (elig[i]) begin
        has_win = 1'b1;
        win     = 3'(i);
      end
    end
  end

  assign int_out = ready && (|elig);

  always_comb begin
    isr_n = isr_q;
    if (eoi_cmd) isr_n[wdata[2:0]] = 1'b0;
    if (ack && has_win && !aeoi_q) isr_n[win] = 1'b1;
    if (init_cmd) isr_n = 8'h00;
  end

  always_comb begin
    edge_n = (edge_q | (irq_in & ~prev_q)) & irq_in;
    if (ack && has_win) edge_n[win] = 1'b0;
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = sel_isr_q ? isr_q : irr;
      2'd1:    rdata = mask_q;
      2'd2:    rdata = trig_q;
      default: rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= ST_OFF;
      mask_q      <= 8'hFF;
      isr_q       <= 8'h00;
      edge_q      <= 8'h00;
      prev_q      <= 8'h00;
      trig_q      <= 8'h00;
      base_q      <= 5'd0;
      aeoi_q      <= 1'b0;
      need_mode_q <= 1'b0;
      sel_isr_q   <= 1'b0;
      cascade_cfg <= 8'h00;
      vec_valid   <= 1'b0;
      vec_out     <= 8'h00;
    end else begin
      isr_q     <= isr_n;
      edge_q    <= edge_n;
      prev_q    <= irq_in;
      vec_valid <= ack;
      if (ack) vec_out <= {base_q, has_win ? win : 3'd7};
      if (wr_en && addr == 2'd2) trig_q <= wdata;
      if (init_cmd) begin
        st          <= ST_BASE;
        mask_q      <= 8'hFF;
        sel_isr_q   <= 1'b0;
        aeoi_q      <= 1'b0;
        need_mode_q <= wdata[0];
      end else if (even_wr) begin
        if (wdata == 8'h0A) sel_isr_q <= 1'b0;
        if (wdata == 8'h0B) sel_isr_q <= 1'b1;
      end
      if (odd_wr) begin
        case (st)
          ST_BASE: begin base_q <= wdata[7:3]; st <= ST_CASC; end
          ST_CASC: begin cascade_cfg <= wdata; st <= need_mode_q ? ST_MODE : ST_RUN; end
          ST_MODE: begin aeoi_q <= wdata[1]; st <= ST_RUN; end
          ST_RUN:  mask_q <= wdata;
          default: ;
        endcase
      end
    end
  end

  a_r2_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
    init_cmd |=> (mask_q == 8'hFF && isr_q == 8'h00 && !int_out));

  a_r5_int_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> (ready && (|(irr & ~mask_q))));

  a_r6_vec_follows_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> vec_valid);

  a_r8_aeoi_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    (aeoi_q && !init_cmd) |=> ((isr_q & ~$past(isr_q)) == 8'h00));

  a_r10_spurious_seven: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !(|elig)) |=> (vec_out[2:0] == 3'd7));

endmodule

// File: tb/sim_prio_intc.sv
module sim_prio_intc;
  logic       clk = 0, rst_n = 0, wr_en = 0, inta = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, irq_in = 0;
  logic [7:0] rdata, vec_out, cascade_cfg;
  logic       int_out, vec_valid;
  int checks = 0, fails = 0;

  prio_intc u0 (.clk, .rst_n, .wr_en, .addr, .wdata, .rdata, .irq_in,
                .int_out, .inta, .vec_valid, .vec_out, .cascade_cfg);

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic do_ack(output logic vld, output logic [7:0] v, output logic vld2);
    @(negedge clk); inta = 1;
    @(negedge clk); inta = 0; vld = vec_valid; v = vec_out;
    @(negedge clk); vld2 = vec_valid;
  endtask

  function automatic logic [3:0] pick(input logic [7:0] req);
    for (int i = 0; i < 8; i++) if (req[i]) return {1'b1, 3'(i)};
    return 4'b0111;
  endfunction

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v, b, m, q;
    logic vl, vl2;
    logic [3:0] p;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 int_out", {7'd0, int_out}, 8'h00);
    chk("R1 vec_valid", {7'd0, vec_valid}, 8'h00);
    rd(1, v); chk("R1 mask", v, 8'hFF);
    rd(0, v); chk("R1 irr", v, 8'h00);
    rd(2, v); chk("R1 trig", v, 8'h00);

    wr(2, 8'hFF);
    irq_in = 8'h04;
    wr(0, 8'h11);
    #1 chk("R2 no int before init", {7'd0, int_out}, 8'h00);
    wr(1, 8'h20); wr(1, 8'h04); wr(1, 8'h01);
    chk("R2 cascade", cascade_cfg, 8'h04);
    rd(1, v); chk("R2 mask ff", v, 8'hFF);
    chk("R3 masked", {7'd0, int_out}, 8'h00);
    wr(1, 8'h00);
    rd(1, v); chk("R3 mask read", v, 8'h00);
    #1 chk("R3 int unmasked", {7'd0, int_out}, 8'h01);

    do_ack(vl, v, vl2);
    chk("R6 vec", v, 8'h22);
    chk("R6 valid", {7'd0, vl}, 8'h01);
    chk("R6 one cycle", {7'd0, vl2}, 8'h00);
    wr(0, 8'h0B); rd(0, v); chk("R4 isr", v, 8'h04);
    wr(0, 8'h0A); rd(0, v); chk("R4 irr", v, 8'h04);

    irq_in = 8'h14; #1;
    chk("R5 lower blocked", {7'd0, int_out}, 8'h00);
    irq_in = 8'h16; #1;
    chk("R5 higher passes", {7'd0, int_out}, 8'h01);
    do_ack(vl, v, vl2);
    chk("R5 vec", v, 8'h21);
    wr(0, 8'h0B); rd(0, v); chk("R6 nested isr", v, 8'h06);
    wr(0, 8'h61); rd(0, v); chk("R7 eoi1", v, 8'h04);
    wr(0, 8'h62); rd(0, v); chk("R7 eoi2", v, 8'h00);

    irq_in = 8'h00; wr(1, 8'hFF);
    do_ack(vl, v, vl2);
    chk("R10 spurious vec", v, 8'h27);
    rd(0, v); chk("R10 isr kept", v, 8'h00);

    wr(1, 8'h00); wr(2, 8'h00); wr(0, 8'h0A);
    rd(2, v); chk("R9 trig", v, 8'h00);
    @(negedge clk); irq_in = 8'h08;
    @(negedge clk); rd(0, v); chk("R9 edge latched", v, 8'h08);
    irq_in = 8'h00;
    @(negedge clk); rd(0, v); chk("R9 edge dropped", v, 8'h00);
    irq_in = 8'h08;
    @(negedge clk);
    do_ack(vl, v, vl2);
    chk("R9 edge vec", v, 8'h23);
    rd(0, v); chk("R9 edge consumed", v, 8'h00);
    wr(0, 8'h63);

    irq_in = 8'h00;
    wr(0, 8'h11); wr(1, 8'h48); wr(1, 8'h00); wr(1, 8'h03);
    rd(1, v); chk("R2 reinit mask", v, 8'hFF);
    wr(2, 8'hFF); wr(1, 8'h00);
    irq_in = 8'h20;
    do_ack(vl, v, vl2);
    chk("R8 vec", v, 8'h4D);
    wr(0, 8'h0B); rd(0, v); chk("R8 isr clear", v, 8'h00);

    irq_in = 8'h00;
    b = 8'($urandom()) & 8'hF8;
    wr(0, 8'h11); wr(1, b); wr(1, 8'h00); wr(1, 8'h01);
    wr(0, 8'h0B);
    for (int k = 0; k < 40; k++) begin
      m = 8'($urandom());
      q = 8'($urandom());
      if (k % 5 == 0) q = 8'h00;
      wr(1, m);
      irq_in = q; #1;
      chk("R5 random int", {7'd0, int_out}, {7'd0, |(q & ~m)});
      p = pick(q & ~m);
      do_ack(vl, v, vl2);
      chk("R6 random vec", v, {b[7:3], p[2:0]});
      rd(0, v);
      chk("R10 random isr", v, p[3] ? (8'h01 << p[2:0]) : 8'h00);
      irq_in = 8'h00;
      wr(0, {5'b01100, p[2:0]});
      rd(0, v); chk("R7 random eoi", v, 8'h00);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule